// File: doc/BRIEF.md
# Twelve-State Hour Counter

This block is a 4-bit synchronous counter whose legal values run from 1 up to 12, after which it returns to 1, the way the hour field of a twelve-hour clock advances. The state is held in four toggle-style bits. On each clock edge a bit either inverts or keeps its value. Whether it inverts is decided by combinational logic that looks only at the present state. The return from 12 to 1 goes through those same toggle enables. No compare-and-clear path is used, and no asynchronous preset or clear is used either.

An enable input lets the counter advance. A synchronous init input forces the value 1 and wins over the enable. A one-cycle wrap pulse marks each pass from 12 back to 1. The four codes outside the legal range (0, 13, 14, 15) cannot be reached through the ports. If one appears anyway, for example after a disturbance of the state, the toggle logic still steers it back into the legal cycle. The true count is then lost until the next init. The asynchronous active-low reset is released synchronously and leaves the counter at 1.

Top module: `cnt12_hour`

## Requirements
- R1: While reset is asserted, and in the first cycles after it is released, count reads 1 and wrap reads 0.
- R2: When init is high at a clock edge, count is 1 after that edge, whatever the value of en. Init never raises wrap.
- R3: When init and en are both low at an edge, count keeps its value and wrap is 0 after that edge.
- R4: When en is high and init is low, a count n in 1..11 becomes n+1 after the edge.
- R5: When en is high and init is low, a count of 12 becomes 1 after the edge. Wrap is high for exactly the one cycle that follows that edge.
- R6: Number the state bits so that bit0 is the LSB (A) and bit3 is the MSB (D). The next state is the present state XOR a toggle vector. That vector is A=1, B=A, C=A·B+C·D and D=A·B·C+C·D while counting is allowed, and it is all zero when counting is not allowed.
- R7: Under the R6 equations the unused codes recover as follows: 0 goes to 1, 13 goes to 2, 14 goes to 3, and 15 goes to 0.
- R8: Over one full lap of 12 advancing edges, bit0 changes 12 times, bit1 changes 6 times, bit2 changes 4 times and bit3 changes 2 times.
- R9: After reset, count never leaves the range 1..12.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| init | input | 1 | Synchronous load of the value 1; has priority over en |
| en | input | 1 | Allows the count to advance on the edge |
| count | output | 4 | Present count, 1..12 |
| wrap | output | 1 | One-cycle pulse after the edge that moves 12 to 1 |

## Verification
The bench goes after three corner cases.

- **The 12-to-1 wrap.** A design that decodes 12 one edge late would show 13. A design that clears instead of toggling would land on 0. Either way the wrap pulse would be missing or last two cycles.
- **Init against a running enable, including init at 12.** Wrong priority shows up as a count of 2, or as a wrap pulse raised by an init.
- **The unused codes.** All sixteen codes are swept through the toggle logic, both with counting allowed and with it blocked. A wrong product term shows up as a lock-up at 15 or a jump to the wrong legal value. A held bit that leaks a toggle shows up as motion while en is low.

Counting the flips of each bit over a lap catches a C or D term that fires too often even when the values on the ports still look right.

// File: rtl/cnt12_pkg.sv
package cnt12_pkg;
  localparam int unsigned CNT_W = 4;
  typedef logic [CNT_W-1:0] cnt_t;
  localparam cnt_t FIRST_CODE = cnt_t'(1);
  localparam cnt_t LAST_CODE  = cnt_t'(12);
  localparam int unsigned SYNC_STAGES = 2;
endpackage

// File: rtl/cnt12_rst_sync.sv
module cnt12_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_async,
  output logic rst_n_sync
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n_async) begin
    if (!rst_n_async) sync_q <= '0;
    else              sync_q <= sync_d;
  end

  assign rst_n_sync = sync_q[STAGES-1];
endmodule

// File: rtl/cnt12_toggle_eq.sv
module cnt12_toggle_eq
  import cnt12_pkg::*;
(
  input  cnt_t cur,
  input  logic run,
  output cnt_t tgl
);
  logic a, b, c, d;
  logic ab, cd;

  always_comb begin
    a  = cur[0];
    b  = cur[1];
    c  = cur[2];
    d  = cur[3];
    ab = a & b;
    cd = c & d;
    tgl[0] = run;
    tgl[1] = run & a;
    tgl[2] = run & (ab | cd);
    tgl[3] = run & ((ab & c) | cd);
  end
endmodule

// File: rtl/cnt12_tbit.sv
module cnt12_tbit #(
  parameter bit RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic load_val,
  input  logic tgl,
  output logic q
);
  logic q_nxt;

  always_comb begin
    if (load) q_nxt = load_val;
    else      q_nxt = q ^ tgl;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= RST_VAL;
    else        q <= q_nxt;
  end
endmodule

// File: rtl/cnt12_hour.sv
module cnt12_hour
  import cnt12_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             init,
  input  logic             en,
  output logic [CNT_W-1:0] count,
  output logic             wrap
);
  logic rst_q_n;
  logic run;
  cnt_t state;
  cnt_t tgl;
  logic wrap_nxt;
  logic wrap_q;

  cnt12_rst_sync #(.STAGES(SYNC_STAGES)) u_rst_sync (
    .clk         (clk),
    .rst_n_async (rst_n),
    .rst_n_sync  (rst_q_n)
  );

  always_comb begin
    run = en & ~init;
  end

  cnt12_toggle_eq u_teq (
    .cur (state),
    .run (run),
    .tgl (tgl)
  );

  for (genvar i = 0; i < CNT_W; i++) begin : g_bit
    cnt12_tbit #(.RST_VAL(FIRST_CODE[i])) u_bit (
      .clk      (clk),
      .rst_n    (rst_q_n),
      .load     (init),
      .load_val (FIRST_CODE[i]),
      .tgl      (tgl[i]),
      .q        (state[i])
    );
  end

  always_comb begin
    wrap_nxt = run & (state == LAST_CODE);
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) wrap_q <= 1'b0;
    else          wrap_q <= wrap_nxt;
  end

  assign count = state;
  assign wrap  = wrap_q;
endmodule

// File: rtl/cnt12_hour_chk.sv
module cnt12_hour_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       init,
  input logic       en,
  input logic [3:0] count,
  input logic       wrap
);
  // R9
  legal_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (count >= 4'd1) && (count <= 4'd12));

  // R2
  init_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    init |=> (count == 4'd1) && !wrap);

  // R3
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!init && !en) |=> $stable(count) && !wrap);

  // R4
  step_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!init && en && count != 4'd12) |=> (count == $past(count) + 4'd1));

  // R5
  wrap_back_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!init && en && count == 4'd12) |=> (count == 4'd1) && wrap);

  // R5
  wrap_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> !wrap);
endmodule

bind cnt12_hour cnt12_hour_chk u_chk (
  .clk   (clk),
  .rst_n (rst_q_n),
  .init  (init),
  .en    (en),
  .count (count),
  .wrap  (wrap)
);

// File: tb/tb_cnt12_hour.sv
module tb_cnt12_hour;
  logic       clk;
  logic       rst_n;
  logic       init;
  logic       en;
  logic [3:0] count;
  logic       wrap;
  int checks;
  int failures;
  bit done;

  logic [3:0] eq_cur;
  logic       eq_run;
  logic [3:0] eq_tgl;

  cnt12_hour dut (
    .clk   (clk),
    .rst_n (rst_n),
    .init  (init),
    .en    (en),
    .count (count),
    .wrap  (wrap)
  );

  cnt12_toggle_eq u_eq (
    .cur (eq_cur),
    .run (eq_run),
    .tgl (eq_tgl)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  function automatic logic [3:0] model_next(input logic [3:0] n);
    case (n)
      4'd0:    return 4'd1;
      4'd12:   return 4'd1;
      4'd13:   return 4'd2;
      4'd14:   return 4'd3;
      4'd15:   return 4'd0;
      default: return n + 4'd1;
    endcase
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  initial begin
    #2000000;
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [3:0] exp;
    logic [3:0] prev;
    int flips [4];
    checks = 0;
    failures = 0;
    done = 0;
    rst_n = 1'b0;
    init = 1'b0;
    en = 1'b0;
    eq_cur = '0;
    eq_run = 1'b0;
    #23;
    // R1 during reset
    check("R1 count in reset", count, 1);
    check("R1 wrap in reset", wrap, 0);
    rst_n = 1'b1;
    tick(); tick(); tick();
    check("R1 count after release", count, 1);
    check("R1 wrap after release", wrap, 0);

    // R4 R5 R9: two full laps with enable held high
    en = 1'b1;
    exp = 4'd1;
    for (int k = 0; k < 4; k++) flips[k] = 0;
    for (int s = 0; s < 24; s++) begin
      prev = count;
      exp = model_next(exp);
      tick();
      check(prev == 4'd12 ? "R5 wrap value" : "R4 step", count, exp);
      check("R5 wrap pulse", wrap, (prev == 4'd12) ? 1 : 0);
      check("R9 range", (count >= 1 && count <= 12) ? 1 : 0, 1);
      if (s < 12)
        for (int k = 0; k < 4; k++) if (prev[k] != count[k]) flips[k]++;
    end
    // R8 flip counts over one lap
    check("R8 bit0 flips", flips[0], 12);
    check("R8 bit1 flips", flips[1], 6);
    check("R8 bit2 flips", flips[2], 4);
    check("R8 bit3 flips", flips[3], 2);

    // R3 enable low holds, alternating pattern
    for (int s = 0; s < 10; s++) begin
      en = s[0];
      prev = count;
      tick();
      if (s[0]) check("R4 gated step", count, model_next(prev));
      else begin
        check("R3 hold", count, prev);
        check("R3 no wrap", wrap, 0);
      end
    end

    // R2 init with en high mid-count
    en = 1'b1;
    init = 1'b1;
    tick();
    check("R2 init with en", count, 1);
    init = 1'b0;
    for (int s = 0; s < 11; s++) tick();
    check("R4 reach 12", count, 12);
    init = 1'b1;
    tick();
    check("R2 init at 12 value", count, 1);
    check("R2 init at 12 no wrap", wrap, 0);
    init = 1'b0;
    tick(); tick();
    en = 1'b0;
    init = 1'b1;
    tick();
    check("R2 init with en low", count, 1);
    init = 1'b0;

    // R6 R7 sweep all codes through the toggle logic
    for (int v = 0; v < 16; v++) begin
      eq_cur = 4'(v);
      eq_run = 1'b1;
      #1;
      check((v == 0 || v > 12) ? "R7 recovery" : "R6 next code",
            eq_cur ^ eq_tgl, model_next(4'(v)));
      eq_run = 1'b0;
      #1;
      check("R6 blocked toggles", eq_tgl, 0);
    end

    // R1 reset mid-count
    en = 1'b1;
    tick(); tick(); tick();
    rst_n = 1'b0;
    #2;
    check("R1 async reset", count, 1);
    rst_n = 1'b1;
    en = 1'b0;
    tick(); tick(); tick();
    check("R1 held after reset", count, 1);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule